// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block sits at the issue stage of an in-order pipeline that feeds four classes of execution unit: integer, add, multiply and divide. Each cycle it looks at one decoded instruction (its unit class, destination, two source registers and flags that say which of them are actually read). It then decides whether that instruction may leave for its unit this cycle or must hold.

Two bit vectors hold the state. The first records which execution units are occupied. The second records which architectural registers have a write still in flight. A granted instruction sets its unit's busy bit and, if it writes a register, that register's pending bit. Each unit returns a writeback strobe and a destination index, and these clear the bits again. Operands are read in order, so a later instruction can never overwrite a value an earlier one still needs. For that reason the block only looks for read-after-write and write-after-write conflicts.

Top module: `issue_scoreboard`

## Requirements
- R1: An instruction is granted only when the busy bit of its unit class is clear (class code 0 integer, 1 add, 2 multiply, 3 divide). A grant makes that unit busy from the next cycle on. A writeback strobe from a unit frees that unit from the next cycle on.
- R2: A grant for an instruction whose write flag is set and whose destination is not register 0 marks that destination pending from the next cycle on.
- R3: A valid instruction stalls when either source whose use flag is set names a pending register.
- R4: A valid instruction with its write flag set stalls when its destination is pending.
- R5: Register 0 never stalls as a source or as a destination, and it is never marked pending. A source whose use flag is clear never stalls. An instruction with its write flag clear marks no register pending.
- R6: Each writeback port that strobes clears the pending bit of the register it names from the next cycle on. Several ports may clear different registers in the same cycle.
- R7: When a grant sets a register and a writeback clears that same register in the same cycle, the register is pending afterwards.
- R8: Hazards are judged on the state held at the start of the cycle. A writeback therefore releases a waiting instruction one cycle later.
- R9: issue_o is high for a valid instruction with no hazard, and stall_o is high for a valid instruction with a hazard. Both are low when no instruction is valid, and they are never high together. No check compares a destination against the sources of older instructions.
- R10: Reset clears all unit busy bits and all register pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Decoded instruction present |
| in_fu_i | input | 2 | Target unit class |
| in_rd_i | input | REG_W | Destination register |
| in_rd_we_i | input | 1 | Instruction writes its destination |
| in_rs1_i | input | REG_W | First source register |
| in_rs1_use_i | input | 1 | First source is read |
| in_rs2_i | input | REG_W | Second source register |
| in_rs2_use_i | input | 1 | Second source is read |
| wb_en_i | input | NUM_FU | Writeback strobe, one per unit class |
| wb_rd_i | input | NUM_FU*REG_W | Writeback destination per unit, port u at bits [u*REG_W +: REG_W] |
| issue_o | output | 1 | Instruction granted this cycle |
| stall_o | output | 1 | Instruction held this cycle |

## Verification
A grant and a writeback can land in the same cycle. They can meet on the same unit, on the same register, or on a register the waiting instruction needs. The bench drives a stalled instruction while the writeback that releases it strobes in that same cycle. It expects the stall to persist in that cycle and the grant to follow one cycle later. It also issues a write to a register while a writeback names that register. A dependent reader in the following cycle must then stall, which shows that the set took priority over the clear.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    FU_INT = 2'd0,
    FU_ADD = 2'd1,
    FU_MUL = 2'd2,
    FU_DIV = 2'd3
  } fu_e;

  localparam int unsigned NUM_FU = 4;
  localparam int unsigned FU_W   = 2;
endpackage

// File: rtl/sb_busy_vec.sv
module sb_busy_vec #(
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_en_i,
  input  logic [IDX_W-1:0]   set_idx_i,
  input  logic [N_UNITS-1:0] clr_en_i,
  output logic [N_UNITS-1:0] busy_o
);
  logic [N_UNITS-1:0] busy_q;

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    logic hit_set;
    assign hit_set = set_en_i && (set_idx_i == IDX_W'(u));

    // set has priority over a same-cycle release
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          busy_q[u] <= 1'b0;
      else if (hit_set)     busy_q[u] <= 1'b1;
      else if (clr_en_i[u]) busy_q[u] <= 1'b0;
    end

    // R1
    busy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_en_i[u] && !hit_set) |=> !busy_q[u]);
  end

  assign busy_o = busy_q;

  // R1
  busy_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> busy_q[$past(set_idx_i)]);
endmodule

// File: rtl/sb_pending_vec.sv
module sb_pending_vec #(
  parameter int unsigned N_REGS  = 32,
  parameter int unsigned N_PORTS = 4,
  localparam int unsigned REG_W  = $clog2(N_REGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     set_en_i,
  input  logic [REG_W-1:0]         set_idx_i,
  input  logic [N_PORTS-1:0]       clr_en_i,
  input  logic [N_PORTS*REG_W-1:0] clr_idx_i,
  output logic [N_REGS-1:0]        pend_o
);
  logic [N_REGS-1:0] pend_q, pend_d, set_mask, clr_mask;

  always_comb begin
    clr_mask = '0;
    for (int p = 0; p < N_PORTS; p++) begin
      if (clr_en_i[p]) clr_mask[clr_idx_i[p*REG_W +: REG_W]] = 1'b1;
    end
    set_mask = '0;
    if (set_en_i) set_mask[set_idx_i] = 1'b1;
  end

  // R7: set wins over a same-register clear
  assign pend_d = (pend_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  // R7
  pend_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> pend_q[$past(set_idx_i)]);

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    logic [REG_W-1:0] idx;
    assign idx = clr_idx_i[p*REG_W +: REG_W];
    // R6
    pend_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_en_i[p] && !(set_en_i && set_idx_i == idx)) |=> !pend_q[$past(idx)]);
  end
endmodule

// File: rtl/sb_hazard.sv
module sb_hazard #(
  parameter int unsigned N_REGS  = 32,
  parameter int unsigned N_UNITS = 4,
  localparam int unsigned REG_W  = $clog2(N_REGS),
  localparam int unsigned IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [N_REGS-1:0]  pend_i,
  input  logic [N_UNITS-1:0] busy_i,
  input  logic [IDX_W-1:0]   fu_i,
  input  logic [REG_W-1:0]   rd_i,
  input  logic               rd_we_i,
  input  logic [REG_W-1:0]   rs1_i,
  input  logic               rs1_use_i,
  input  logic [REG_W-1:0]   rs2_i,
  input  logic               rs2_use_i,
  output logic               unit_busy_o,
  output logic               raw_o,
  output logic               waw_o
);
  logic rs1_live, rs2_live, rd_live;

  // register 0 is never tracked
  assign rs1_live = rs1_use_i && (rs1_i != '0);
  assign rs2_live = rs2_use_i && (rs2_i != '0);
  assign rd_live  = rd_we_i   && (rd_i  != '0);

  assign unit_busy_o = busy_i[fu_i];
  assign raw_o       = (rs1_live && pend_i[rs1_i]) || (rs2_live && pend_i[rs2_i]);
  assign waw_o       = rd_live && pend_i[rd_i];
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned NUM_FU   = sb_pkg::NUM_FU,
  localparam int unsigned REG_W   = $clog2(NUM_REGS),
  localparam int unsigned FU_W    = (NUM_FU > 1) ? $clog2(NUM_FU) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [FU_W-1:0]         in_fu_i,
  input  logic [REG_W-1:0]        in_rd_i,
  input  logic                    in_rd_we_i,
  input  logic [REG_W-1:0]        in_rs1_i,
  input  logic                    in_rs1_use_i,
  input  logic [REG_W-1:0]        in_rs2_i,
  input  logic                    in_rs2_use_i,
  input  logic [NUM_FU-1:0]       wb_en_i,
  input  logic [NUM_FU*REG_W-1:0] wb_rd_i,
  output logic                    issue_o,
  output logic                    stall_o
);
  logic [NUM_REGS-1:0] pend;
  logic [NUM_FU-1:0]   busy;
  logic                unit_busy, raw, waw, hazard, pend_set;

  sb_hazard #(.N_REGS(NUM_REGS), .N_UNITS(NUM_FU)) u_hazard (
    .pend_i      (pend),
    .busy_i      (busy),
    .fu_i        (in_fu_i),
    .rd_i        (in_rd_i),
    .rd_we_i     (in_rd_we_i),
    .rs1_i       (in_rs1_i),
    .rs1_use_i   (in_rs1_use_i),
    .rs2_i       (in_rs2_i),
    .rs2_use_i   (in_rs2_use_i),
    .unit_busy_o (unit_busy),
    .raw_o       (raw),
    .waw_o       (waw)
  );

  assign hazard   = unit_busy || raw || waw;
  assign issue_o  = in_valid_i && !hazard;
  assign stall_o  = in_valid_i && hazard;
  assign pend_set = issue_o && in_rd_we_i && (in_rd_i != '0);

  sb_busy_vec #(.N_UNITS(NUM_FU)) u_busy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (issue_o),
    .set_idx_i (in_fu_i),
    .clr_en_i  (wb_en_i),
    .busy_o    (busy)
  );

  sb_pending_vec #(.N_REGS(NUM_REGS), .N_PORTS(NUM_FU)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (pend_set),
    .set_idx_i (in_rd_i),
    .clr_en_i  (wb_en_i),
    .clr_idx_i (wb_rd_i),
    .pend_o    (pend)
  );

  // R9
  grant_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(issue_o && stall_o));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> (!issue_o && !stall_o));

  // R5
  zero_never_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend[0]);
endmodule

// File: tb/sim_issue_scoreboard.sv
module sim_issue_scoreboard;
  localparam int NR = 32;
  localparam int NF = 4;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_rd_we = 1'b0, in_rs1_use = 1'b0, in_rs2_use = 1'b0;
  logic [1:0] in_fu = '0;
  logic [RW-1:0] in_rd = '0, in_rs1 = '0, in_rs2 = '0;
  logic [NF-1:0] wb_en = '0;
  logic [NF*RW-1:0] wb_rd = '0;
  logic issue, stall;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  issue_scoreboard #(.NUM_REGS(NR), .NUM_FU(NF)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_fu_i(in_fu), .in_rd_i(in_rd), .in_rd_we_i(in_rd_we),
    .in_rs1_i(in_rs1), .in_rs1_use_i(in_rs1_use), .in_rs2_i(in_rs2), .in_rs2_use_i(in_rs2_use),
    .wb_en_i(wb_en), .wb_rd_i(wb_rd), .issue_o(issue), .stall_o(stall)
  );

  // {valid, fu[2], rd[5], we, rs1[5], u1, rs2[5], u2, wbv, wbu[2], wbrd[5], exp_issue, exp_stall}
  localparam int NV = 13;
  localparam logic [30:0] TBL [NV] = '{
    {1'b1,2'd2,5'd6, 1'b1,5'd4, 1'b1,5'd2,1'b1, 1'b0,2'd0,5'd0,  1'b1,1'b0}, // R1 R2 mul rd6
    {1'b1,2'd1,5'd8, 1'b1,5'd2, 1'b1,5'd2,1'b1, 1'b0,2'd0,5'd0,  1'b1,1'b0}, // R2 add rd8
    {1'b1,2'd1,5'd9, 1'b1,5'd1, 1'b1,5'd1,1'b1, 1'b1,2'd1,5'd8,  1'b0,1'b1}, // R1 R8 add busy, wb same cycle
    {1'b1,2'd1,5'd10,1'b1,5'd6, 1'b1,5'd1,1'b1, 1'b0,2'd0,5'd0,  1'b0,1'b1}, // R3 rs1 pending
    {1'b1,2'd1,5'd10,1'b1,5'd1, 1'b1,5'd6,1'b1, 1'b0,2'd0,5'd0,  1'b0,1'b1}, // R3 rs2 pending
    {1'b1,2'd1,5'd10,1'b1,5'd1, 1'b1,5'd6,1'b0, 1'b0,2'd0,5'd0,  1'b1,1'b0}, // R5 unused rs2
    {1'b1,2'd0,5'd6, 1'b1,5'd1, 1'b1,5'd1,1'b1, 1'b1,2'd2,5'd6,  1'b0,1'b1}, // R4 R8 waw, wb same cycle
    {1'b1,2'd0,5'd6, 1'b1,5'd6, 1'b1,5'd1,1'b1, 1'b0,2'd0,5'd0,  1'b1,1'b0}, // R6 R8 released
    {1'b1,2'd3,5'd0, 1'b1,5'd1, 1'b1,5'd1,1'b1, 1'b0,2'd0,5'd0,  1'b1,1'b0}, // R5 rd zero
    {1'b0,2'd0,5'd0, 1'b0,5'd0, 1'b0,5'd0,1'b0, 1'b1,2'd0,5'd6,  1'b0,1'b0}, // R9 idle
    {1'b1,2'd0,5'd7, 1'b1,5'd0, 1'b1,5'd6,1'b1, 1'b0,2'd0,5'd0,  1'b1,1'b0}, // R5 rs1 zero
    {1'b1,2'd2,5'd11,1'b1,5'd10,1'b1,5'd0,1'b0, 1'b1,2'd1,5'd10, 1'b0,1'b1}, // R3 R8
    {1'b1,2'd2,5'd11,1'b1,5'd10,1'b1,5'd0,1'b0, 1'b0,2'd0,5'd0,  1'b1,1'b0}  // R6
  };

  task automatic check(input string tag, input logic exp_i, input logic exp_s);
    n_chk++;
    if (issue !== exp_i || stall !== exp_s) begin
      n_err++;
      $display("FAIL %s: issue=%b stall=%b expected issue=%b stall=%b",
               tag, issue, stall, exp_i, exp_s);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] fu, input logic [RW-1:0] rd,
                       input logic we, input logic [RW-1:0] r1, input logic u1,
                       input logic [RW-1:0] r2, input logic u2,
                       input logic [NF-1:0] wbe, input logic [NF*RW-1:0] wbr);
    @(negedge clk);
    in_valid = v; in_fu = fu; in_rd = rd; in_rd_we = we;
    in_rs1 = r1; in_rs1_use = u1; in_rs2 = r2; in_rs2_use = u2;
    wb_en = wbe; wb_rd = wbr;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0; wb_en = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [NF*RW-1:0] wbr;
    logic [NF-1:0]    wbe;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R10: quiet after reset, any instruction grants
    drive(1'b0, 2'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, '0, '0);
    check("R10 idle after reset", 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] e;
      e = TBL[i];
      wbe = '0; wbr = '0;
      if (e[9]) begin
        wbe[e[8:7]] = 1'b1;
        wbr[e[8:7]*RW +: RW] = e[6:2];
      end
      drive(e[30], e[29:28], e[27:23], e[22], e[21:17], e[16], e[15:11], e[10], wbe, wbr);
      check($sformatf("table step %0d", i), e[1], e[0]);
    end

    // R10: mul unit busy and rd11 pending before reset; both cleared after
    do_reset();
    drive(1'b1, 2'd2, 5'd11, 1'b1, 5'd11, 1'b1, 5'd7, 1'b1, '0, '0);
    check("R10 state cleared by reset", 1'b1, 1'b0);
    do_reset();

    // R7: add writes rd12 while divide port names rd12
    wbe = 4'b1000; wbr = '0; wbr[3*RW +: RW] = 5'd12;
    drive(1'b1, 2'd1, 5'd12, 1'b1, 5'd1, 1'b1, 5'd1, 1'b1, wbe, wbr);
    check("R7 grant with colliding clear", 1'b1, 1'b0);
    drive(1'b1, 2'd0, 5'd1, 1'b1, 5'd12, 1'b1, 5'd0, 1'b0, '0, '0);
    check("R7 set wins, reader stalls", 1'b0, 1'b1);

    drive(1'b1, 2'd0, 5'd5, 1'b1, 5'd1, 1'b1, 5'd1, 1'b1, '0, '0);
    check("R2 int rd5", 1'b1, 1'b0);
    drive(1'b1, 2'd2, 5'd13, 1'b1, 5'd1, 1'b1, 5'd1, 1'b1, '0, '0);
    check("R2 mul rd13", 1'b1, 1'b0);

    // R6: three ports clear at once
    wbe = 4'b0111; wbr = '0;
    wbr[0*RW +: RW] = 5'd5; wbr[1*RW +: RW] = 5'd12; wbr[2*RW +: RW] = 5'd13;
    drive(1'b0, 2'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, wbe, wbr);
    check("R9 idle during multi clear", 1'b0, 1'b0);
    drive(1'b1, 2'd3, 5'd20, 1'b1, 5'd5, 1'b1, 5'd13, 1'b1, '0, '0);
    check("R6 multi-port clear rs5 rs13", 1'b1, 1'b0);
    drive(1'b1, 2'd0, 5'd12, 1'b1, 5'd12, 1'b1, 5'd0, 1'b0, '0, '0);
    check("R6 R1 rd12 and int unit freed", 1'b1, 1'b0);

    // R5: write flag clear marks nothing
    drive(1'b1, 2'd2, 5'd21, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, '0, '0);
    check("R5 no-write grant", 1'b1, 1'b0);
    drive(1'b1, 2'd1, 5'd22, 1'b1, 5'd21, 1'b1, 5'd0, 1'b0, '0, '0);
    check("R5 rd21 not pending", 1'b1, 1'b0);
    // R1: divide still busy from rd20
    drive(1'b1, 2'd3, 5'd23, 1'b1, 5'd1, 1'b0, 5'd1, 1'b0, '0, '0);
    check("R1 divide busy", 1'b0, 1'b1);

    drive(1'b0, 2'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, '0, '0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule